// File: doc/BRIEF.md
# External DMA Request Front-End

This block sits between four external peripherals and the hardware handshaking side of a DMA controller. Each peripheral signals that its data threshold has been reached by pulling its request pin low. The pins are asynchronous to the controller clock. The front end brings each pin into the clock domain through a two-flop chain and inverts it into an active-high request. A transfer begins only when that synchronized request rises; a request that simply stays asserted does not begin another.

On each rising edge the block gives a one-cycle start pulse for that request. It also sets a held request on the matching handshaking interface. External request n drives interface n+1, so interfaces 1 to 4 of the five are used and interface 0 stays idle. The held request is cleared by the controller's acknowledge on the same interface, not by the peripheral releasing its pin. If an acknowledge and a new rising edge arrive in the same cycle, the new edge wins. Arbitration between the channels and the transfer engine are handled elsewhere.

Top module: `ext_dreq_frontend`

## Requirements
- R1: While `rst_n` is low, and for as long afterwards as every request pin stays high, all bits of `start_o` and `hs_req_o` are 0. A pin that is high at reset release causes no start pulse.
- R2: If `req_n_i[n]` is low at rising clock edge k and was high before, `start_o[n]` is 1 only between edges k+1 and k+2. It is 0 both before and after that cycle.
- R3: `hs_req_o[n+1]` becomes 1 at the edge that ends the start pulse of request n. It then stays 1, whatever the pin does, until it is acknowledged.
- R4: An acknowledge `hs_ack_i[n+1]` = 1 at an edge where `hs_req_o[n+1]` is 1 and no new start is pending clears `hs_req_o[n+1]` at that edge.
- R5: A request pin that is held low gives exactly one start pulse, however long it stays low.
- R6: If `hs_ack_i[n+1]` is 1 in the same cycle as `start_o[n]`, `hs_req_o[n+1]` is 1 after that edge.
- R7: `hs_req_o[0]` is always 0. An acknowledge on interface 0, or on an interface whose held request is 0, changes no output.
- R8: Request n maps only to interface n+1 (bit n of `start_o`, bit n+1 of `hs_req_o`/`hs_ack_i`). Every channel behaves independently, including when several pins fall at the same time.
- R9: After an acknowledge, a pin that is still low gives no new start. A new start needs the pin to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n_i | input | 4 | Asynchronous active-low request pins, bit n = external request n |
| hs_ack_i | input | 5 | Acknowledge per handshaking interface, bit k = interface k |
| hs_req_o | output | 5 | Held request per handshaking interface, bit k = interface k |
| start_o | output | 4 | One-cycle start pulse per external request |

## Verification
Several internal faults show up as a start pulse at the wrong time. A stuck or skipped synchronizer stage moves the pulse one cycle earlier or later. A broken edge flop turns the pulse into a level. Either one is visible at `start_o` within three clock edges of the pin falling. A held-request flop that ignores the acknowledge, lets the acknowledge win over a new edge, or is wired to the wrong interface index is visible on `hs_req_o` one edge after the acknowledge or start. The bench sweeps every combination of falling pins with full and partial acknowledges, and runs the collision and re-arm sequences per channel.

// File: rtl/dreq_fe_pkg.sv
// Package: shared defaults, channel output record and request-to-interface
// mapping for the external DMA request front end.
package dreq_fe_pkg;

    localparam int unsigned DEF_NUM_REQ    = 4;  // external request pins
    localparam int unsigned DEF_NUM_IF     = 5;  // handshaking interfaces
    localparam int unsigned DEF_IF_BASE    = 1;  // interface of request 0
    localparam int unsigned DEF_SYNC_DEPTH = 2;  // synchronizer flops

    // Per-channel outputs gathered in one record.
    typedef struct packed {
        logic start;
        logic held;
    } chan_out_t;

    // Interface index served by a given external request.
    function automatic int unsigned if_of_req(input int unsigned req_idx,
                                              input int unsigned base);
        return req_idx + base;
    endfunction

endpackage

// File: rtl/dreq_sync.sv
// Module: dreq_sync
// Brings one asynchronous active-low request pin into the clock domain and
// inverts it to active high through a chain of DEPTH flops.
// Assumes: DEPTH >= 2; reset loads the inactive level (pin high = 0 here),
// so releasing reset with the pin high never looks like a request.
module dreq_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic req_sync
);

    logic [DEPTH-1:0] chain;

    // Shift the inverted pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[DEPTH-2:0], ~pin_n};
        end
    end

    assign req_sync = chain[DEPTH-1];

endmodule

// File: rtl/dreq_edge.sv
// Module: dreq_edge
// Keeps the synchronized request for one more cycle and reports its rising
// edge as a single-cycle pulse.
// Assumes: the input is already in the clock domain.
module dreq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic rise
);

    logic req_prev;

    // Delay stage that the edge compare uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= 1'b0;
        end else begin
            req_prev <= req_sync;
        end
    end

    // Rising edge: request present now, absent one cycle earlier.
    assign rise = req_sync & ~req_prev;

    // R2
    pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R5
    level_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync && $stable(req_sync)) |-> !rise);

endmodule

// File: rtl/dreq_hold.sv
// Module: dreq_hold
// Held request toward one handshaking interface. It is set by a start pulse
// and cleared by that interface's acknowledge; a start in the same cycle as
// an acknowledge keeps the request set.
// Assumes: ack belongs to the same interface as this channel.
module dreq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic held_o
);

    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o <= 1'b0;
        end else if (set_i) begin
            held_o <= 1'b1;
        end else if (ack_i) begin
            held_o <= 1'b0;
        end
    end

    // R3
    set_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> held_o);

    // R3
    stays_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !ack_i) |=> held_o);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && ack_i && !set_i) |=> !held_o);

    // R9
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_o && !set_i) |=> !held_o);

endmodule

// File: rtl/ext_dreq_frontend.sv
// Module: ext_dreq_frontend
// Front end for asynchronous active-low external DMA request pins. Each pin
// is synchronized, its rising (active-high) edge is detected, and a held
// request is raised on handshaking interface IF_BASE+n until acknowledged.
// Assumes: NUM_IF >= IF_BASE + NUM_REQ; interfaces outside the mapped range
// are driven idle and their acknowledges are ignored.
module ext_dreq_frontend
    import dreq_fe_pkg::*;
#(
    parameter int unsigned NUM_REQ    = DEF_NUM_REQ,
    parameter int unsigned NUM_IF     = DEF_NUM_IF,
    parameter int unsigned IF_BASE    = DEF_IF_BASE,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_n_i,
    input  logic [NUM_IF-1:0]  hs_ack_i,
    output logic [NUM_IF-1:0]  hs_req_o,
    output logic [NUM_REQ-1:0] start_o
);

    localparam int unsigned IF_LAST = IF_BASE + NUM_REQ - 1;

    chan_out_t [NUM_REQ-1:0] chan;
    logic                    unused_ack_bits;

    // Acknowledge bits of unmapped interfaces are not used.
    assign unused_ack_bits = ^hs_ack_i;

    // One synchronizer, edge detector and held request per external pin.
    for (genvar n = 0; n < NUM_REQ; n++) begin : g_chan
        localparam int unsigned IFX = if_of_req(n, IF_BASE);
        logic req_sync;
        logic rise;

        dreq_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (req_n_i[n]),
            .req_sync (req_sync)
        );

        dreq_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_sync (req_sync),
            .rise     (rise)
        );

        dreq_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (rise),
            .ack_i  (hs_ack_i[IFX]),
            .held_o (chan[n].held)
        );

        assign chan[n].start = rise;
        assign start_o[n]    = chan[n].start;

        // R8
        start_to_own_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[n] |=> hs_req_o[IFX]);
    end

    // Route held requests onto the interface vector; unmapped ones stay idle.
    for (genvar k = 0; k < NUM_IF; k++) begin : g_if
        if (k >= IF_BASE && k <= IF_LAST) begin : g_mapped
            assign hs_req_o[k] = chan[k-IF_BASE].held;
        end else begin : g_idle
            assign hs_req_o[k] = 1'b0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (hs_req_o == '0 && start_o == '0));

endmodule

// File: tb/ext_dreq_frontend_tb.sv
module ext_dreq_frontend_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n_i = 4'hF;
    logic [4:0] hs_ack_i = 5'h0;
    logic [4:0] hs_req_o;
    logic [3:0] start_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    ext_dreq_frontend u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n_i  (req_n_i),
        .hs_ack_i (hs_ack_i),
        .hs_req_o (hs_req_o),
        .start_o  (start_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    initial begin
        logic [3:0] low;
        tick(3);
        chk("R1 start in reset", start_o, 0);
        chk("R1 hs_req in reset", hs_req_o, 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 start after reset", start_o, 0);
        chk("R1 hs_req after reset", hs_req_o, 0);
        hs_ack_i = 5'h1F;
        tick();
        hs_ack_i = 5'h0;
        chk("R7 ack while idle", {27'd0, hs_req_o}, 0);

        // Sweep every combination of falling pins.
        for (int m = 1; m < 16; m++) begin
            req_n_i = ~m[3:0];
            tick();
            chk("R2 no early start", start_o, 0);
            tick();
            chk("R2 start pulse", start_o, m);
            chk("R3 not yet held", hs_req_o, 0);
            tick();
            chk("R2 pulse ends", start_o, 0);
            chk("R8 held on own interface", hs_req_o, {m[3:0], 1'b0});
            tick(3);
            chk("R5 no restart while low", start_o, 0);
            req_n_i = 4'hF;
            tick(3);
            chk("R3 held after pin release", hs_req_o, {m[3:0], 1'b0});
            low = m[3:0] & (~m[3:0] + 4'd1);
            hs_ack_i = {low, 1'b1};
            tick();
            hs_ack_i = 5'h0;
            chk("R4 partial ack", hs_req_o, {m[3:0] & ~low, 1'b0});
            chk("R7 if0 idle", hs_req_o[0], 0);
            hs_ack_i = {m[3:0], 1'b0};
            tick();
            hs_ack_i = 5'h0;
            chk("R4 full ack", hs_req_o, 0);
            tick(2);
            chk("R1 quiet after release", start_o, 0);
        end

        // R9: acknowledge while pin still low, then re-arm.
        for (int c = 0; c < 4; c++) begin
            req_n_i[c] = 1'b0;
            tick(3);
            chk("R3 held", hs_req_o[c+1], 1);
            hs_ack_i[c+1] = 1'b1;
            tick();
            hs_ack_i = 5'h0;
            chk("R4 cleared with pin low", hs_req_o[c+1], 0);
            tick(4);
            chk("R9 no start while still low", start_o, 0);
            chk("R9 no re-hold while still low", hs_req_o, 0);
            req_n_i[c] = 1'b1;
            tick(3);
            req_n_i[c] = 1'b0;
            tick(2);
            chk("R9 restart after re-arm", start_o, 4'b1 << c);
            tick();
            chk("R9 held after re-arm", hs_req_o, 5'b10 << c);
            req_n_i[c] = 1'b1;
            hs_ack_i = 5'h1F;
            tick();
            hs_ack_i = 5'h0;
            tick(3);
        end

        // R6: acknowledge collides with a new start on each channel.
        for (int c = 0; c < 4; c++) begin
            req_n_i[c] = 1'b0;
            tick(3);
            req_n_i[c] = 1'b1;
            tick(3);
            chk("R3 held before collision", hs_req_o[c+1], 1);
            req_n_i[c] = 1'b0;
            tick(2);
            chk("R6 start present", start_o, 4'b1 << c);
            hs_ack_i[c+1] = 1'b1;
            tick();
            hs_ack_i = 5'h0;
            chk("R6 start wins over ack", hs_req_o[c+1], 1);
            req_n_i[c] = 1'b1;
            hs_ack_i[c+1] = 1'b1;
            tick();
            hs_ack_i = 5'h0;
            chk("R4 cleared after collision", hs_req_o, 0);
            tick(3);
        end

        summary();
        $finish;
    end

endmodule